// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a descriptor-driven Ethernet DMA engine. Software places a ring of receive descriptors in shared memory. Each descriptor is 8 bytes long and holds a 16-bit status/control field, a 16-bit length field and a 32-bit buffer pointer. The engine accepts a descriptor only when that descriptor's empty flag is set. It stores the bytes of one frame from a byte-stream input into the descriptor's buffer. It then writes back the frame length and an error summary, and clears the empty flag so that software owns the descriptor again.

Two things set the ring order. A descriptor with its wrap flag set sends the engine back to the ring base. Any other descriptor moves the engine on to the next descriptor, 8 bytes further. If the engine finds a descriptor that software has not handed back, it stops polling. It starts again only when software writes the arm value to the poll port. The ring base is taken from an input while reception is disabled. Software normally sets the maximum frame length to 1518. Buffers hold at most 1520 bytes.

The engine has one simple memory port. Reads return their data one cycle after the request. Writes carry a byte enable for each lane.

Top module: `rx_bd_ring`

## Requirements
- R1: A descriptor occupies two 32-bit words. The word at the descriptor address carries status in bits 31:16 and length in bits 15:0. The next word, at address + 4, is the buffer byte address. Every descriptor read and every status write uses a word-aligned address.
- R2: The engine fills a descriptor only when status bit 15 (word bit 31) is set. When it reads a descriptor with that bit clear, it keeps rx_ready low and makes no further memory access until the next arm write.
- R3: A poll-port write of exactly 0x01000000 restarts descriptor polling. A write of any other value has no effect.
- R4: After a descriptor whose status bit 13 (word bit 29) is set, the next descriptor is read at the ring base. After any other descriptor, it is read at the current address + 8.
- R5: Frame byte i goes to buffer address + i. A byte at word offset k is carried in bits (31-8k) down to (24-8k), with only byte-enable bit 3-k set.
- R6: The written-back length equals the number of bytes in the frame, frame check sequence included.
- R7: Write-back status has bit 15 cleared and bits 5:0 replaced. Bit 5 is set when the length exceeds max_len, and bits 4:0 are zero. All other status bits keep the value that was fetched.
- R8: Bytes at frame index BUF_BYTES and above are not stored, but they still count in the length.
- R9: The status/length write reaches memory two clock edges after the edge that accepts the last byte. Every data byte of the frame reaches memory before it.
- R10: After reset, rx_ready and mem_en are low and polling is not armed. The ring base is loaded while rx_en is low.
- R11: rx_ready is high only while a descriptor is owned. It drops on the cycle after the last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable; while low the ring base is loaded |
| ring_base | input | AW | Byte address of the first descriptor |
| max_len | input | 16 | Frames longer than this are flagged as overlength |
| poll_wr | input | 1 | Poll-port write strobe |
| poll_wdata | input | 32 | Poll-port write data |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Engine accepts a byte |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 4 | Byte write enables; zero means read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |

## Verification
The bench's memory model records three clock edges: the edge that accepts the last byte, the edge where the descriptor write lands, and the edge where each read lands. It checks that the write lands exactly two edges after the accept. Memory contents are checked only several cycles after a frame ends, when every byte write and the status write have landed. The stall, ignore and re-arm cases are judged from counts of reads taken over fixed idle windows of 10 to 30 cycles. These windows are longer than the five cycles a descriptor fetch takes from arming to rx_ready. A length sweep from 1 to 20 bytes runs over a 16-byte buffer with a 12-byte limit, so it crosses both the overlength limit and the buffer end.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int HW         = 16;
  localparam int WW         = 2 * HW;
  localparam int DESC_BYTES = 8;
  localparam logic [WW-1:0] ARM_VALUE = 32'h0100_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_WT0, ST_RD1, ST_WT1, ST_RECV, ST_WB, ST_NEXT
  } rxr_state_e;
endpackage

// File: rtl/rxr_poll.sv
module rxr_poll
  import rxr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [WW-1:0] wdata,
  input  logic          stall,
  output logic          active
);
  always_ff @(posedge clk) begin
    if (rst)                            active <= 1'b0;
    else if (wr && wdata == ARM_VALUE)  active <= 1'b1;
    else if (stall)                     active <= 1'b0;
  end
endmodule

// File: rtl/rxr_ptr.sv
module rxr_ptr
  import rxr_pkg::*;
#(
  parameter int AW = 32
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          wrap_sel,
  output logic [AW-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (load) cur <= base;
    else if (adv)  cur <= wrap_sel ? base : cur + AW'(DESC_BYTES);
  end
endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 1520,
  parameter int EMPTY_BIT = 15,
  parameter int WRAP_BIT  = 13,
  parameter int OVL_BIT   = 5,
  parameter int ERR_BITS  = 6
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          active,
  input  logic [AW-1:0] cur,
  input  logic [HW-1:0] max_len,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          stall,
  output logic          adv,
  output logic          wrap_sel,
  output logic          mem_en,
  output logic [3:0]    mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [WW-1:0] mem_wdata,
  input  logic [WW-1:0] mem_rdata
);
  localparam logic [HW-1:0] CLR_MASK =
    (HW'(1) << EMPTY_BIT) | HW'((1 << ERR_BITS) - 1);
  localparam logic [HW-1:0] BUF_LIM = HW'(BUF_BYTES);

  rxr_state_e    st;
  logic [HW-1:0] stat_q, cnt;
  logic [AW-1:0] buf_q, byte_addr;
  logic [HW-1:0] wb_stat;
  logic          ovl;

  always_comb begin
    byte_addr = buf_q + AW'(cnt);
    ovl       = cnt > max_len;
    wb_stat   = (stat_q & ~CLR_MASK) | (HW'(ovl) << OVL_BIT);
    stall     = (st == ST_WT0) && !mem_rdata[HW+EMPTY_BIT];
    adv       = (st == ST_NEXT);
    wrap_sel  = stat_q[WRAP_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_en    <= 1'b0;
      mem_we    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rx_ready  <= 1'b0;
      cnt       <= '0;
      buf_q     <= '0;
      stat_q    <= '0;
    end else begin
      mem_en <= 1'b0;
      mem_we <= '0;
      case (st)
        ST_IDLE: if (en && active) begin
          mem_en   <= 1'b1;
          mem_addr <= cur;
          st       <= ST_RD0;
        end
        ST_RD0: st <= ST_WT0;
        ST_WT0: begin
          if (!mem_rdata[HW+EMPTY_BIT]) begin
            st <= ST_IDLE;
          end else begin
            stat_q   <= mem_rdata[WW-1:HW];
            mem_en   <= 1'b1;
            mem_addr <= cur + AW'(4);
            st       <= ST_RD1;
          end
        end
        ST_RD1: st <= ST_WT1;
        ST_WT1: begin
          buf_q    <= mem_rdata[AW-1:0];
          cnt      <= '0;
          rx_ready <= 1'b1;
          st       <= ST_RECV;
        end
        ST_RECV: if (rx_valid && rx_ready) begin
          if (cnt < BUF_LIM) begin
            mem_en    <= 1'b1;
            mem_we    <= 4'b1000 >> byte_addr[1:0];
            mem_addr  <= byte_addr;
            mem_wdata <= {4{rx_data}};
          end
          cnt <= cnt + HW'(1);
          if (rx_last) begin
            rx_ready <= 1'b0;
            st       <= ST_WB;
          end
        end
        ST_WB: begin
          mem_en    <= 1'b1;
          mem_we    <= 4'hF;
          mem_addr  <= cur;
          mem_wdata <= {wb_stat, cnt};
          st        <= ST_NEXT;
        end
        ST_NEXT: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 1520,
  parameter int EMPTY_BIT = 15,
  parameter int WRAP_BIT  = 13,
  parameter int OVL_BIT   = 5,
  parameter int ERR_BITS  = 6
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic [AW-1:0] ring_base,
  input  logic [15:0]   max_len,
  input  logic          poll_wr,
  input  logic [31:0]   poll_wdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          mem_en,
  output logic [3:0]    mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  logic          active, stall, adv, wrap_sel;
  logic [AW-1:0] cur;

  rxr_poll u_poll (
    .clk(clk), .rst(rst), .wr(poll_wr), .wdata(poll_wdata),
    .stall(stall), .active(active)
  );

  rxr_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load(!rx_en), .base(ring_base),
    .adv(adv), .wrap_sel(wrap_sel), .cur(cur)
  );

  rxr_fsm #(
    .AW(AW), .BUF_BYTES(BUF_BYTES), .EMPTY_BIT(EMPTY_BIT),
    .WRAP_BIT(WRAP_BIT), .OVL_BIT(OVL_BIT), .ERR_BITS(ERR_BITS)
  ) u_fsm (
    .clk(clk), .rst(rst), .en(rx_en), .active(active), .cur(cur),
    .max_len(max_len), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .stall(stall), .adv(adv),
    .wrap_sel(wrap_sel), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/rx_bd_ring_chk.sv
module rx_bd_ring_chk #(
  parameter int AW        = 32,
  parameter int EMPTY_BIT = 15
)(
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          rx_last,
  input logic          mem_en,
  input logic [3:0]    mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata
);
  logic last_hs, wb_wr, byte_wr;
  assign last_hs = rx_valid && rx_ready && rx_last;
  assign wb_wr   = mem_en && (mem_we == 4'hF);
  assign byte_wr = mem_en && (mem_we != 4'h0) && (mem_we != 4'hF);

  AST_WB_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wb_wr |-> !mem_wdata[16+EMPTY_BIT]); // R7
  AST_WB_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last_hs |=> ##1 wb_wr); // R9
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    last_hs |=> !rx_ready); // R11
  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (rst)
    byte_wr |-> ($countones(mem_we) == 1 && mem_we == (4'b1000 >> mem_addr[1:0]))); // R5
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !byte_wr) |-> (mem_addr[1:0] == 2'b00)); // R1
endmodule

bind rx_bd_ring rx_bd_ring_chk #(.AW(AW), .EMPTY_BIT(EMPTY_BIT)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_last(rx_last), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/rx_bd_ring_bench.sv
module rx_bd_ring_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int BUF  = 16;
  localparam int MAXL = 12;

  logic clk = 1'b0, rst = 1'b1, rx_en = 1'b0;
  logic [AW-1:0] ring_base = 32'h40;
  logic [15:0] max_len = 16'(MAXL);
  logic poll_wr = 1'b0;
  logic [31:0] poll_wdata = '0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic mem_en;
  logic [3:0] mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_bd_ring #(.AW(AW), .BUF_BYTES(BUF)) u_rx_bd_ring (
    .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(ring_base),
    .max_len(max_len), .poll_wr(poll_wr), .poll_wdata(poll_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_ready(rx_ready), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // shared memory model: 256 words, read data one cycle after request
  logic [31:0] mem [0:255];
  logic h_en = 1'b0;
  logic [31:0] h_addr = '0, h_data = '0;
  int cyc, last_hs_cyc, wb_cyc, rd_cnt;
  logic [31:0] last_rd_addr;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA5A5_A5A5;
      cyc <= 0; last_hs_cyc <= 0; wb_cyc <= 0; rd_cnt <= 0;
      last_rd_addr <= '0; mem_rdata <= '0;
    end else begin
      cyc <= cyc + 1;
      if (rx_valid && rx_ready && rx_last) last_hs_cyc <= cyc;
      if (h_en) mem[h_addr[9:2]] <= h_data;
      else if (mem_en) begin
        if (mem_we == 4'h0) begin
          mem_rdata    <= mem[mem_addr[9:2]];
          rd_cnt       <= rd_cnt + 1;
          last_rd_addr <= mem_addr;
        end else begin
          for (int b = 0; b < 4; b++)
            if (mem_we[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          if (mem_we == 4'hF) wb_cyc <= cyc;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(int a);
    return mem[(a >> 2) & 255][31 - 8*(a % 4) -: 8];
  endfunction

  task automatic host_wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); h_en = 1'b1; h_addr = a; h_data = d;
    @(negedge clk); h_en = 1'b0;
  endtask

  task automatic set_desc(int d, logic [15:0] st, logic [31:0] b);
    host_wr(d, {st, 16'h0});
    host_wr(d + 4, b);
  endtask

  task automatic arm(logic [31:0] v);
    @(negedge clk); poll_wr = 1'b1; poll_wdata = v;
    @(negedge clk); poll_wr = 1'b0;
  endtask

  task automatic send_frame(int len, logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = seed + 8'(i); rx_last = (i == len - 1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic check_frame(int d, int b, logic [15:0] st0, int len, logic [7:0] seed);
    logic [31:0] w;
    logic [15:0] exp_st;
    repeat (6) @(negedge clk);
    w = mem[d >> 2];
    exp_st = (st0 & ~16'h803F) | ((len > MAXL) ? 16'h0020 : 16'h0000);
    chk("R6 length", 32'(w[15:0]), 32'(len));
    chk("R7 status", 32'(w[31:16]), 32'(exp_st));
    chk("R9 writeback delay", 32'(wb_cyc - last_hs_cyc), 32'd2);
    for (int i = 0; i < len && i < BUF; i++)
      chk("R5 data byte", 32'(mbyte(b + i)), 32'(seed + 8'(i)));
    if (len > BUF) chk("R8 beyond buffer", 32'(mbyte(b + BUF)), 32'hA5);
  endtask

  initial begin : main
    int rd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset rx_ready", 32'(rx_ready), 32'd0);
    chk("R10 reset mem_en", 32'(mem_en), 32'd0);

    set_desc(32'h40, 16'h903F, 32'h100);
    set_desc(32'h48, 16'h8000, 32'h140);
    set_desc(32'h50, 16'hA001, 32'h180);
    @(negedge clk); rx_en = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 not armed after reset", 32'(rd_cnt), 32'd0);
    arm(32'h0000_0001);
    repeat (10) @(negedge clk);
    chk("R3 wrong value ignored reads", 32'(rd_cnt), 32'd0);
    chk("R3 wrong value ignored ready", 32'(rx_ready), 32'd0);

    arm(32'h0100_0000);
    send_frame(5, 8'h10);
    check_frame(32'h40, 32'h100, 16'h903F, 5, 8'h10);
    send_frame(14, 8'h30);
    check_frame(32'h48, 32'h140, 16'h8000, 14, 8'h30);
    send_frame(20, 8'h50);
    rd0 = rd_cnt;
    check_frame(32'h50, 32'h180, 16'hA001, 20, 8'h50);
    repeat (20) @(negedge clk);
    chk("R2 single fetch then stall", 32'(rd_cnt - rd0), 32'd1);
    chk("R4 wrap to base", last_rd_addr, 32'h40);
    chk("R2 ready low when stalled", 32'(rx_ready), 32'd0);
    chk("R11 ready low between frames", 32'(rx_ready), 32'd0);

    set_desc(32'h40, 16'h8000, 32'h100);
    rd0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk("R2 no repoll without arm", 32'(rd_cnt - rd0), 32'd0);
    arm(32'h0100_0000);
    send_frame(3, 8'h70);
    check_frame(32'h40, 32'h100, 16'h8000, 3, 8'h70);
    repeat (10) @(negedge clk);
    chk("R4 advance by 8", last_rd_addr, 32'h48);
    chk("R1 descriptor word0 aligned read", 32'(last_rd_addr[1:0]), 32'd0);

    @(negedge clk); rx_en = 1'b0; ring_base = 32'h60;
    repeat (2) @(negedge clk); rx_en = 1'b1;
    for (int len = 1; len <= 20; len++) begin
      set_desc(32'h60, 16'hA000, 32'h1C0);
      arm(32'h0100_0000);
      send_frame(len, 8'(len * 7));
      check_frame(32'h60, 32'h1C0, 16'hA000, len, 8'(len * 7));
      repeat (8) @(negedge clk);
      chk("R10 new base used on wrap", last_rd_addr, 32'h60);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule